// File: doc/BRIEF.md
# Convert-and-Select Serial Readout Controller

This block is the digital half of a 16-bit successive-approximation converter that runs a three-wire serial mode. One input line serves two purposes. Its rising edge starts a conversion. Its falling edge, once the conversion is over, selects the part for readout. A parallel sample word stands in for the analog core and is captured when each conversion starts. The conversion then runs for a fixed number of system-clock cycles and does not depend on the select line, so the host may drop the line during that time to talk to other devices on a shared bus.

After the conversion the block stays in acquisition until the host lowers the select line. The output enable then rises and the most significant bit is presented at once. Each falling edge of the serial clock moves the next lower bit onto the data line. The output returns to high impedance after the sixteenth falling edge of the serial clock, or earlier if the select line rises first. The select line and the serial clock are asynchronous to the system clock. Each is synchronised and edge-detected before use.

Top module: `sar_serial_emu`

## Requirements
- R1: While reset is asserted and after its release, with the select line held high, `sdo_oe` and `conv_active` are 0.
- R2: A synchronised rising edge of `cnv_sel` during acquisition sets `conv_active` on the next cycle, forces `sdo_oe` to 0 and captures `sample_in` in that cycle.
- R3: `conv_active` stays high for exactly CONV_CYC system-clock cycles whatever `cnv_sel` does meanwhile. A rising edge during a conversion does not restart it.
- R4: A falling edge of `cnv_sel` while `conv_active` is high, including its last cycle, leaves `sdo_oe` at 0. When a conversion ends with `cnv_sel` high, `sdo_oe` stays 0 and no busy indication appears.
- R5: A synchronised falling edge of `cnv_sel` while `conv_active` is low sets `sdo_oe` to 1 on the next cycle, with `sdo` equal to bit 15 (the MSB) of the captured word.
- R6: Each synchronised falling edge of `sclk` while `sdo_oe` is 1 presents the next lower bit on `sdo`. Between such edges `sdo` holds its value. Edges of `sclk` while `sdo_oe` is 0 have no effect.
- R7: The sixteenth `sclk` falling edge after the select falls returns `sdo_oe` to 0.
- R8: A rising edge of `cnv_sel` during readout returns `sdo_oe` to 0 in the same cycle in which the new conversion starts.
- R9: Changes of `sample_in` after capture do not alter the bits shifted out. `sdo` reads 0 whenever `sdo_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which also times the conversion |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnv_sel | input | 1 | Convert start (rising) and readout select (falling), asynchronous |
| sclk | input | 1 | Serial clock from the host, asynchronous |
| sample_in | input | DATA_W | Stand-in result of the analog core |
| sdo | output | 1 | Serial data, 0 when not enabled |
| sdo_oe | output | 1 | Enable for the tri-state data pad |
| conv_active | output | 1 | High during the conversion phase |

## Verification
The end of a conversion and a falling edge of the select line can fall in the same system cycle. The bench provokes this by lowering the select line at CONV_CYC-1, CONV_CYC and CONV_CYC+1 cycles after the start edge. A behavioural model counts the synchroniser latency and predicts `conv_active`, `sdo_oe` and `sdo` on every clock. It expects the coincident edge to be discarded and the later one to open the readout. A select rise that arrives together with a serial-clock fall during readout is judged the same way. The rise must win.

// File: rtl/sar_emu_pkg.sv
package sar_emu_pkg;
   typedef enum logic {
      PH_ACQ  = 1'b0,
      PH_CONV = 1'b1
   } phase_t;
endpackage

// File: rtl/sar_edge_sync.sv
module sar_edge_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic level,
   output logic rise,
   output logic fall
);
   if (STAGES < 2) begin : g_bad_stages
      $error("sar_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;
   logic              last;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= RST_VAL;
            else        chain[0] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= RST_VAL;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last <= RST_VAL;
      else        last <= chain[STAGES-1];
   end

   assign level = chain[STAGES-1];
   assign rise  = level & ~last;
   assign fall  = ~level & last;
endmodule

// File: rtl/sar_conv_timer.sv
module sar_conv_timer
   import sar_emu_pkg::*;
#(
   parameter int CYCLES = 40
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic active
);
   if (CYCLES < 2) begin : g_bad_cycles
      $error("sar_conv_timer: CYCLES must be at least 2");
   end

   localparam int CW = $clog2(CYCLES);

   phase_t        phase;
   logic [CW-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase  <= PH_ACQ;
         remain <= '0;
      end else begin
         case (phase)
            PH_ACQ: if (start) begin
               phase  <= PH_CONV;
               remain <= CW'(CYCLES - 1);
            end
            PH_CONV: if (remain == '0) phase <= PH_ACQ;
                     else              remain <= remain - 1'b1;
            default: phase <= PH_ACQ;
         endcase
      end
   end

   assign active = (phase == PH_CONV);
endmodule

// File: rtl/sar_shift_out.sv
module sar_shift_out #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              kill,
   input  logic              step,
   input  logic [DATA_W-1:0] word,
   output logic              oe,
   output logic              sdo
);
   localparam int NW = $clog2(DATA_W);

   logic [DATA_W-1:0] sh;
   logic [NW-1:0]     nbits;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oe    <= 1'b0;
         sh    <= '0;
         nbits <= '0;
      end else if (kill) begin
         oe <= 1'b0;
      end else if (load) begin
         oe    <= 1'b1;
         sh    <= word;
         nbits <= '0;
      end else if (step && oe) begin
         if (nbits == NW'(DATA_W - 1)) begin
            oe <= 1'b0;
         end else begin
            sh    <= {sh[DATA_W-2:0], 1'b0};
            nbits <= nbits + 1'b1;
         end
      end
   end

   assign sdo = oe & sh[DATA_W-1];

   // R6
   sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (oe && !step && !load && !kill) |=> $stable(sdo));
endmodule

// File: rtl/sar_serial_emu.sv
module sar_serial_emu #(
   parameter int DATA_W   = 16,
   parameter int CONV_CYC = 40,
   parameter int SYNC_STG = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cnv_sel,
   input  logic              sclk,
   input  logic [DATA_W-1:0] sample_in,
   output logic              sdo,
   output logic              sdo_oe,
   output logic              conv_active
);
   if (DATA_W < 2) begin : g_bad_width
      $error("sar_serial_emu: DATA_W must be at least 2");
   end

   logic cs_lvl, cs_rise, cs_fall;
   logic sk_lvl, sk_rise, sk_fall;
   logic start;
   logic [DATA_W-1:0] word_q;

   sar_edge_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b1)) i_cs_sync (
      .clk(clk), .rst_n(rst_n), .din(cnv_sel),
      .level(cs_lvl), .rise(cs_rise), .fall(cs_fall));

   sar_edge_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b0)) i_sk_sync (
      .clk(clk), .rst_n(rst_n), .din(sclk),
      .level(sk_lvl), .rise(sk_rise), .fall(sk_fall));

   assign start = cs_rise & ~conv_active;

   sar_conv_timer #(.CYCLES(CONV_CYC)) i_timer (
      .clk(clk), .rst_n(rst_n), .start(start), .active(conv_active));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     word_q <= '0;
      else if (start) word_q <= sample_in;
   end

   sar_shift_out #(.DATA_W(DATA_W)) i_shift (
      .clk(clk), .rst_n(rst_n),
      .load(cs_fall & ~conv_active), .kill(cs_rise), .step(sk_fall),
      .word(word_q), .oe(sdo_oe), .sdo(sdo));

   // R4
   oe_off_during_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      conv_active |-> !sdo_oe);

   // R2
   rise_starts_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_rise && !conv_active) |=> (conv_active && !sdo_oe));

   // R8
   rise_kills_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_rise |=> !sdo_oe);

   // R5
   msb_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_fall && !conv_active && !cs_rise) |=> (sdo_oe && sdo == $past(word_q[DATA_W-1])));

   // R9
   quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sdo_oe |-> !sdo);
endmodule

// File: tb/test_sar_serial_emu.sv
module test_sar_serial_emu;
   localparam int DW   = 16;
   localparam int CONV = 40;
   localparam int SYNC = 2;

   logic          clk = 1'b0, rst_n = 1'b0, cnv_sel = 1'b1, sclk = 1'b0;
   logic [DW-1:0] sample_in = '0;
   logic          sdo, sdo_oe, conv_active;

   sar_serial_emu #(.DATA_W(DW), .CONV_CYC(CONV), .SYNC_STG(SYNC)) i_sar_serial_emu (
      .clk(clk), .rst_n(rst_n), .cnv_sel(cnv_sel), .sclk(sclk),
      .sample_in(sample_in), .sdo(sdo), .sdo_oe(sdo_oe), .conv_active(conv_active));

   always #10 clk = ~clk;

   int    errors = 0, checks = 0, cycles = 0;
   string tag = "R1";

   // behavioural reference
   bit            cs_q[$], sk_q[$];
   bit            m_conv, m_oe, was, rise, fall, sf;
   int            m_cnt, m_n;
   logic [DW-1:0] m_word, m_sh;

   always @(posedge clk) begin
      if (!rst_n) begin
         cs_q.delete(); sk_q.delete();
         for (int i = 0; i < SYNC + 1; i++) begin
            cs_q.push_back(1'b1); sk_q.push_back(1'b0);
         end
         m_conv = 0; m_oe = 0; m_cnt = 0; m_n = 0; m_word = '0; m_sh = '0;
      end else begin
         rise = cs_q[1] && !cs_q[0];
         fall = !cs_q[1] && cs_q[0];
         sf   = !sk_q[1] && sk_q[0];
         was  = m_conv;
         if (was) begin
            if (m_cnt == CONV - 1) m_conv = 0;
            else m_cnt++;
         end
         if (rise) begin
            m_oe = 0;
            if (!was) begin m_conv = 1; m_cnt = 0; m_word = sample_in; end
         end else if (fall && !was) begin
            m_oe = 1; m_sh = m_word; m_n = 0;
         end else if (sf && m_oe) begin
            if (m_n == DW - 1) m_oe = 0;
            else begin m_sh = {m_sh[DW-2:0], 1'b0}; m_n++; end
         end
         cs_q.push_back(cnv_sel); void'(cs_q.pop_front());
         sk_q.push_back(sclk);    void'(sk_q.pop_front());
      end
   end

   task automatic check1(string what, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%b expected=%b at cycle %0d", tag, what, act, exp, cycles);
      end
   endtask

   always @(negedge clk) begin
      check1("conv_active", conv_active, m_conv);
      check1("sdo_oe", sdo_oe, m_oe);
      check1("sdo", sdo, m_oe ? m_sh[DW-1] : 1'b0);
   end

   task automatic wait_cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_cs(bit v);
      @(negedge clk) cnv_sel = v;
   endtask

   task automatic pulse_sclk(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) sclk = 1'b1;
         wait_cyc(3);
         sclk = 1'b0;
         wait_cyc(3);
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      tag = "R1";
      wait_cyc(5);
      @(negedge clk) rst_n = 1'b1;
      wait_cyc(8);

      // conversion start with select games during it
      tag = "R2"; sample_in = 16'hA5C3;
      set_cs(0); wait_cyc(4); set_cs(1); wait_cyc(6);
      tag = "R4"; set_cs(0); sample_in = 16'h0000; wait_cyc(5);
      tag = "R3"; set_cs(1); wait_cyc(3); set_cs(0); wait_cyc(3); set_cs(1);
      wait_cyc(CONV + 10);

      // full readout, sample changing meanwhile
      tag = "R5"; set_cs(0); wait_cyc(5);
      tag = "R6"; sample_in = 16'hFFFF; pulse_sclk(15);
      tag = "R7"; pulse_sclk(3); wait_cyc(4);
      tag = "R9"; set_cs(1); wait_cyc(CONV + 10);

      // early abort of readout
      tag = "R5"; sample_in = 16'h3C5A; set_cs(0); wait_cyc(5);
      tag = "R8"; pulse_sclk(5); set_cs(1); wait_cyc(CONV + 10);
      tag = "R6"; pulse_sclk(4);
      tag = "R5"; set_cs(0); wait_cyc(5); pulse_sclk(16);
      set_cs(1); wait_cyc(CONV + 10);

      // rise coincident with a serial-clock fall
      tag = "R8"; set_cs(0); wait_cyc(5);
      @(negedge clk) sclk = 1'b1; wait_cyc(3);
      sclk = 1'b0; cnv_sel = 1'b1; wait_cyc(CONV + 10);

      // select fall around the end of conversion
      for (int d = CONV - 1; d <= CONV + 1; d++) begin
         tag = (d <= CONV) ? "R4" : "R5";
         sample_in = 16'h8001 ^ 16'(d);
         set_cs(0); wait_cyc(5);
         @(negedge clk) cnv_sel = 1'b1;
         repeat (d) @(negedge clk);
         cnv_sel = 1'b0;
         wait_cyc(8);
         tag = "R6"; pulse_sclk(16);
         tag = "R4"; set_cs(1); wait_cyc(CONV + 10);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule